// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small stored-program processor. It owns the program counter, the instruction register and a control address register (the microstep pointer). A constant microstep store is addressed by that pointer alone. The store produces the control word that drives the ALU, the register file and the RAM of an external datapath. The block also decides on its own when the program counter is written.

Every instruction runs in the same order. The first microstep fetches the word, the second dispatches on it, and then comes the instruction's own routine. Fetch captures the program word and bumps the program counter. Dispatch looks up the first microstep of the routine from the opcode's type and subtype. The last microstep of each routine sends the pointer back to the fetch entry.

Conditional branches rely on the datapath. The datapath subtracts the two named registers and returns a zero flag. Two bits in the microword gate that flag, one for branch-on-equal and one for branch-on-not-equal, and the gated result makes the program counter write conditional.

Top module: `mseq_ctrl`

## Requirements
- R1: While `rst_ni` is low, the program counter, the microstep pointer and the instruction register are all zero.
- R2: At microstep 0, `ir_load_o` is 1 and the instruction register captures `prog_word_i`. On the next edge the program counter increments by one and the pointer moves to 1.
- R3: At microstep 1, no register or RAM write is issued. The next pointer value comes from a table indexed by opcode bits [4:3] (type: 00 arithmetic, 01 memory, 10 control) and bits [2:0] (subtype).
- R4: Arithmetic subtypes 0 to 5 (add, sub, and, or, decode, set-on-less) dispatch to microsteps 2 to 7. Each runs one step with `alu_op_o` equal to the subtype, `reg_we_o` = 1 and select bit 3 = 0 (destination is the bits [16:13] field). The pointer then returns to 0.
- R5: Arithmetic subtype 7 (set immediate) dispatches to microstep 8. It runs one step with `reg_we_o` = 1, select bit 2 = 1 (write data is the value field) and select bit 3 = 1 (destination is the bits [8:5] field).
- R6: Memory subtype 0 (load) dispatches to microstep 9 and runs two steps. Both steps assert `ram_rd_o` and select bit 4 (RAM address from the value field). Only the second step asserts `reg_we_o`, with select bit 1 (write data from RAM).
- R7: Memory subtype 1 (store) dispatches to microstep 11 and runs two steps. Both steps assert select bit 4. Only the second step asserts `ram_we_o`.
- R8: Control subtype 0 (jump) dispatches to microstep 13. It writes the program counter with bits [28:13] whatever the zero flag and the register fields hold.
- R9: Control subtype 1 (branch if not equal) dispatches to microstep 14 with `alu_op_o` = 1 (subtract). The program counter takes bits [28:13] only when `alu_zero_i` is 0. Otherwise it keeps the incremented value.
- R10: Control subtype 2 (branch if equal) dispatches to microstep 15 with `alu_op_o` = 1. The program counter takes bits [28:13] only when `alu_zero_i` is 1.
- R11: Type 11, and any unused subtype, dispatches straight back to microstep 0 with no write issued, so execution continues at the next word.
- R12: The field outputs come from the instruction register: `ra_o` = [8:5], `rb_o` = [12:9], `rd_o` = [16:13], `imm_o` = [24:9] and `tgt_o` = [28:13].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_word_i | input | 32 | Program ROM word at `pc_o` |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| pc_o | output | 16 | Program counter, the program ROM address |
| car_o | output | 4 | Current microstep pointer |
| ir_load_o | output | 1 | Instruction register load this cycle |
| pc_we_o | output | 1 | Effective program counter write this cycle |
| alu_op_o | output | 3 | ALU operation code |
| reg_we_o | output | 1 | Register file write enable |
| ram_rd_o | output | 1 | RAM read enable |
| ram_we_o | output | 1 | RAM write enable |
| mux_sel_o | output | 5 | Selects: [0] PC target, [1] write data from RAM, [2] write data from value field, [3] destination from [8:5], [4] RAM address from value field |
| ra_o | output | 4 | First register field |
| rb_o | output | 4 | Second register field |
| rd_o | output | 4 | Target register field |
| imm_o | output | 16 | Value / memory address field |
| tgt_o | output | 16 | Branch target field |

## Verification
The zero flag matters in exactly one cycle, the execute microstep of a conditional branch. Every branch outcome therefore has to be reached from the program stream. The bench keeps a 16-word program that the design's own `pc_o` indexes, and sets the zero flag just before each branch's fetch. It then observes the taken and not-taken outcomes of both conditional branches as the next `pc_o`. A jump is run with the flag high and nonzero register fields to show that both are ignored, and undefined opcodes are placed in the stream to show the fall-through to the next word.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int CAR_W  = 4;
  localparam int PC_W   = 16;
  localparam int IW     = 32;
  localparam int ALU_W  = 3;
  localparam int NSEL   = 5;
  localparam int RF_W   = 4;
  localparam int N_ALU  = 6;

  // instruction field positions (decoded by datapath too)
  localparam int OPC_LSB = 0;
  localparam int RA_LSB  = 5;
  localparam int RB_LSB  = 9;
  localparam int RD_LSB  = 13;
  localparam int IMM_LSB = 9;
  localparam int TGT_LSB = 13;

  localparam int SEL_PC_TGT  = 0;
  localparam int SEL_WB_MEM  = 1;
  localparam int SEL_WB_IMM  = 2;
  localparam int SEL_WDST_R1 = 3;
  localparam int SEL_RAM_IMM = 4;

  localparam logic [1:0] TY_ALU = 2'b00;
  localparam logic [1:0] TY_MEM = 2'b01;
  localparam logic [1:0] TY_CTL = 2'b10;
  localparam logic [2:0] SUB_SETI = 3'd7;

  localparam logic [CAR_W-1:0] U_FETCH = 4'd0;
  localparam logic [CAR_W-1:0] U_DISP  = 4'd1;
  localparam logic [CAR_W-1:0] U_ALU   = 4'd2;
  localparam logic [CAR_W-1:0] U_SETI  = U_ALU + CAR_W'(N_ALU);
  localparam logic [CAR_W-1:0] U_LD    = 4'd9;
  localparam logic [CAR_W-1:0] U_ST    = 4'd11;
  localparam logic [CAR_W-1:0] U_J     = 4'd13;
  localparam logic [CAR_W-1:0] U_JNE   = 4'd14;
  localparam logic [CAR_W-1:0] U_JE    = 4'd15;

  typedef enum logic [1:0] {
    CAR_ZERO = 2'd0,
    CAR_INC  = 2'd1,
    CAR_DISP = 2'd2
  } car_ctl_e;

  typedef struct packed {
    logic [ALU_W-1:0] alu_op;
    logic             pc_ld;
    logic             ir_ld;
    logic             ram_rd;
    logic             ram_we;
    logic             reg_we;
    car_ctl_e         car_ctl;
    logic [NSEL-1:0]  sel;
    logic             br_eq;
    logic             br_ne;
  } uword_t;
endpackage

// File: rtl/mseq_ustore.sv
module mseq_ustore
  import mseq_pkg::*;
(
  input  logic [CAR_W-1:0] car_i,
  output uword_t           uw_o
);
  always_comb begin
    uw_o         = '0;
    uw_o.car_ctl = CAR_ZERO;
    if (car_i >= U_ALU && car_i < U_SETI) begin
      uw_o.alu_op = ALU_W'(car_i - U_ALU);
      uw_o.reg_we = 1'b1;
    end else begin
      case (car_i)
        U_FETCH: begin
          uw_o.ir_ld   = 1'b1;
          uw_o.pc_ld   = 1'b1;
          uw_o.car_ctl = CAR_INC;
        end
        U_DISP: uw_o.car_ctl = CAR_DISP;
        U_SETI: begin
          uw_o.reg_we             = 1'b1;
          uw_o.sel[SEL_WB_IMM]    = 1'b1;
          uw_o.sel[SEL_WDST_R1]   = 1'b1;
        end
        U_LD: begin
          uw_o.ram_rd             = 1'b1;
          uw_o.sel[SEL_RAM_IMM]   = 1'b1;
          uw_o.car_ctl            = CAR_INC;
        end
        U_LD + 4'd1: begin
          uw_o.ram_rd             = 1'b1;
          uw_o.reg_we             = 1'b1;
          uw_o.sel[SEL_RAM_IMM]   = 1'b1;
          uw_o.sel[SEL_WB_MEM]    = 1'b1;
          uw_o.sel[SEL_WDST_R1]   = 1'b1;
        end
        U_ST: begin
          uw_o.sel[SEL_RAM_IMM]   = 1'b1;
          uw_o.car_ctl            = CAR_INC;
        end
        U_ST + 4'd1: begin
          uw_o.sel[SEL_RAM_IMM]   = 1'b1;
          uw_o.ram_we             = 1'b1;
        end
        U_J: begin
          uw_o.pc_ld              = 1'b1;
          uw_o.sel[SEL_PC_TGT]    = 1'b1;
        end
        U_JNE: begin
          uw_o.alu_op             = 3'd1;
          uw_o.br_ne              = 1'b1;
          uw_o.sel[SEL_PC_TGT]    = 1'b1;
        end
        U_JE: begin
          uw_o.alu_op             = 3'd1;
          uw_o.br_eq              = 1'b1;
          uw_o.sel[SEL_PC_TGT]    = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mseq_dispatch.sv
module mseq_dispatch
  import mseq_pkg::*;
(
  input  logic [4:0]       opc_i,
  output logic [CAR_W-1:0] entry_o
);
  logic [1:0] ty;
  logic [2:0] sub;
  assign ty  = opc_i[4:3];
  assign sub = opc_i[2:0];

  always_comb begin
    entry_o = U_FETCH;
    case (ty)
      TY_ALU: begin
        if (int'(sub) < N_ALU)    entry_o = U_ALU + CAR_W'(sub);
        else if (sub == SUB_SETI) entry_o = U_SETI;
      end
      TY_MEM: begin
        if (sub == 3'd0)      entry_o = U_LD;
        else if (sub == 3'd1) entry_o = U_ST;
      end
      TY_CTL: begin
        if (sub == 3'd0)      entry_o = U_J;
        else if (sub == 3'd1) entry_o = U_JNE;
        else if (sub == 3'd2) entry_o = U_JE;
      end
      default: entry_o = U_FETCH;
    endcase
  end
endmodule

// File: rtl/mseq_car.sv
module mseq_car
  import mseq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  car_ctl_e         ctl_i,
  input  logic [CAR_W-1:0] disp_i,
  output logic [CAR_W-1:0] car_o
);
  logic [CAR_W-1:0] car_d, car_q;

  always_comb begin
    case (ctl_i)
      CAR_INC:  car_d = car_q + 1'b1;
      CAR_DISP: car_d = disp_i;
      default:  car_d = U_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) car_q <= U_FETCH;
    else         car_q <= car_d;
  end

  assign car_o = car_q;

  a_r2_fetch_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    car_q == U_FETCH |=> car_q == U_DISP);
  a_r3_dispatch_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    car_q == U_DISP |=> car_q == $past(disp_i));
  a_r4_alu_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_q >= U_ALU && car_q <= U_SETI) |=> car_q == U_FETCH);
  a_r6_load_two_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    car_q == U_LD |=> car_q == U_LD + 4'd1 ##1 car_q == U_FETCH);
  a_r7_store_two_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    car_q == U_ST |=> car_q == U_ST + 4'd1 ##1 car_q == U_FETCH);
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IW-1:0]    prog_word_i,
  input  logic             alu_zero_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [CAR_W-1:0] car_o,
  output logic             ir_load_o,
  output logic             pc_we_o,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             reg_we_o,
  output logic             ram_rd_o,
  output logic             ram_we_o,
  output logic [NSEL-1:0]  mux_sel_o,
  output logic [RF_W-1:0]  ra_o,
  output logic [RF_W-1:0]  rb_o,
  output logic [RF_W-1:0]  rd_o,
  output logic [PC_W-1:0]  imm_o,
  output logic [PC_W-1:0]  tgt_o
);
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [IW-1:0]    ir_q;
  logic [CAR_W-1:0] car, disp;
  uword_t           uw;
  logic             pc_we;

  mseq_ustore u_ustore (.car_i(car), .uw_o(uw));

  mseq_dispatch u_disp (.opc_i(ir_q[OPC_LSB +: 5]), .entry_o(disp));

  mseq_car u_car (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (uw.car_ctl),
    .disp_i (disp),
    .car_o  (car)
  );

  assign tgt_o = ir_q[TGT_LSB +: PC_W];
  assign imm_o = ir_q[IMM_LSB +: PC_W];
  assign ra_o  = ir_q[RA_LSB +: RF_W];
  assign rb_o  = ir_q[RB_LSB +: RF_W];
  assign rd_o  = ir_q[RD_LSB +: RF_W];

  // branch bits gate the zero flag into a conditional PC write
  assign pc_we = uw.pc_ld | (uw.br_eq & alu_zero_i) | (uw.br_ne & ~alu_zero_i);
  assign pc_d  = uw.sel[SEL_PC_TGT] ? tgt_o : pc_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (pc_we)    pc_q <= pc_d;
      if (uw.ir_ld) ir_q <= prog_word_i;
    end
  end

  assign pc_o      = pc_q;
  assign car_o     = car;
  assign ir_load_o = uw.ir_ld;
  assign pc_we_o   = pc_we;
  assign alu_op_o  = uw.alu_op;
  assign reg_we_o  = uw.reg_we;
  assign ram_rd_o  = uw.ram_rd;
  assign ram_we_o  = uw.ram_we;
  assign mux_sel_o = uw.sel;

  a_r2_ir_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    car == U_FETCH |=> ir_q == $past(prog_word_i) && pc_q == $past(pc_q) + 1'b1);
  a_r3_no_write_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    car <= U_DISP |-> !reg_we_o && !ram_we_o);
  a_r8_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    car == U_J |=> pc_q == $past(tgt_o));
  a_r9_jne_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car == U_JNE && !alu_zero_i) |=> pc_q == $past(tgt_o));
  a_r10_je_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car == U_JE && !alu_zero_i) |=> $stable(pc_q));
endmodule

// File: tb/mseq_ctrl_tb.sv
`timescale 1ns/1ps
module mseq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] prog_word;
  logic        zero = 1'b0;
  logic [15:0] pc_o, imm_o, tgt_o;
  logic [3:0]  car_o, ra_o, rb_o, rd_o;
  logic        ir_load_o, pc_we_o, reg_we_o, ram_rd_o, ram_we_o;
  logic [2:0]  alu_op_o;
  logic [4:0]  mux_sel_o;
  logic [31:0] rom [0:15];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mseq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_word_i(prog_word), .alu_zero_i(zero),
    .pc_o(pc_o), .car_o(car_o), .ir_load_o(ir_load_o), .pc_we_o(pc_we_o),
    .alu_op_o(alu_op_o), .reg_we_o(reg_we_o), .ram_rd_o(ram_rd_o),
    .ram_we_o(ram_we_o), .mux_sel_o(mux_sel_o), .ra_o(ra_o), .rb_o(rb_o),
    .rd_o(rd_o), .imm_o(imm_o), .tgt_o(tgt_o));

  always_comb prog_word = rom[pc_o[3:0]];

  function automatic logic [31:0] mk_r(input logic [1:0] ty, input logic [2:0] sub,
                                       input logic [3:0] a, b, d);
    return {15'd0, d, b, a, ty, sub};
  endfunction
  function automatic logic [31:0] mk_i(input logic [1:0] ty, input logic [2:0] sub,
                                       input logic [3:0] a, input logic [15:0] v);
    return {7'd0, v, a, ty, sub};
  endfunction
  function automatic logic [31:0] mk_b(input logic [1:0] ty, input logic [2:0] sub,
                                       input logic [3:0] a, b, input logic [15:0] t);
    return {3'd0, t, b, a, ty, sub};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // fetch + dispatch, leaves at the first microstep after dispatch
  task automatic fetch_disp(input logic [15:0] pc, input logic [3:0] ent);
    chk(car_o == 4'd0 && ir_load_o, "R2 fetch step", car_o, 0);
    chk(pc_o == pc, "R2 pc at fetch", pc_o, pc);
    cyc();
    chk(car_o == 4'd1, "R2 car advance", car_o, 1);
    chk(pc_o == pc + 16'd1, "R2 pc increment", pc_o, pc + 16'd1);
    chk(!reg_we_o && !ram_we_o, "R3 no write at dispatch", {reg_we_o, ram_we_o}, 0);
    cyc();
    chk(car_o == ent, "R3 dispatch entry", car_o, ent);
  endtask

  task automatic t_reset();
    repeat (3) cyc();
    chk(pc_o == 16'd0 && car_o == 4'd0, "R1 reset pc/car", {pc_o, car_o}, 0);
    chk(tgt_o == 16'd0 && imm_o == 16'd0, "R1 reset ir", {tgt_o, imm_o}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_arith(input logic [15:0] pc, input logic [2:0] sub,
                         input logic [3:0] a, b, d);
    fetch_disp(pc, 4'd2 + 4'(sub));
    chk(alu_op_o == sub, "R4 alu op", alu_op_o, sub);
    chk(reg_we_o && !mux_sel_o[3], "R4 write to rd", {reg_we_o, mux_sel_o}, 5'h10);
    chk(ra_o == a && rb_o == b && rd_o == d, "R12 reg fields", {ra_o, rb_o, rd_o}, {a, b, d});
    cyc();
    chk(car_o == 4'd0, "R4 return to fetch", car_o, 0);
  endtask

  task automatic t_seti();
    fetch_disp(16'd2, 4'd8);
    chk(reg_we_o && mux_sel_o[2] && mux_sel_o[3], "R5 set imm", mux_sel_o, 5'b01100);
    chk(imm_o == 16'h1234 && ra_o == 4'd5, "R12 imm field", imm_o, 16'h1234);
    cyc();
    chk(car_o == 4'd0, "R5 single step", car_o, 0);
  endtask

  task automatic t_load();
    fetch_disp(16'd3, 4'd9);
    chk(ram_rd_o && !reg_we_o && mux_sel_o[4], "R6 load step1", {ram_rd_o, reg_we_o}, 2'b10);
    cyc();
    chk(car_o == 4'd10 && ram_rd_o && reg_we_o && mux_sel_o[1], "R6 load step2",
        {car_o, ram_rd_o, reg_we_o}, {4'd10, 2'b11});
    cyc();
    chk(car_o == 4'd0, "R6 load return", car_o, 0);
  endtask

  task automatic t_store();
    fetch_disp(16'd4, 4'd11);
    chk(!ram_we_o && mux_sel_o[4], "R7 store step1", ram_we_o, 0);
    cyc();
    chk(car_o == 4'd12 && ram_we_o && mux_sel_o[4], "R7 store step2", {car_o, ram_we_o}, {4'd12, 1'b1});
    cyc();
    chk(car_o == 4'd0 && pc_o == 16'd5, "R7 store return", {car_o, pc_o}, 5);
  endtask

  task automatic t_branch(input logic [15:0] pc, input logic [3:0] ent, input logic z,
                          input bit cond, input bit taken, input logic [15:0] exp_pc,
                          input string tag);
    zero = z;
    fetch_disp(pc, ent);
    chk(pc_we_o == taken, {tag, " pc write"}, pc_we_o, taken);
    if (cond) chk(alu_op_o == 3'd1, {tag, " subtract"}, alu_op_o, 1);
    cyc();
    chk(car_o == 4'd0 && pc_o == exp_pc, {tag, " next pc"}, pc_o, exp_pc);
  endtask

  task automatic t_undef(input logic [15:0] pc);
    fetch_disp(pc, 4'd0);
    chk(pc_o == pc + 16'd1 && !reg_we_o && !ram_we_o, "R11 fall through", pc_o, pc + 16'd1);
  endtask

  initial begin
    rom[0]  = mk_r(2'b00, 3'd0, 4'd1, 4'd2, 4'd3);
    rom[1]  = mk_r(2'b00, 3'd5, 4'd4, 4'd5, 4'd6);
    rom[2]  = mk_i(2'b00, 3'd7, 4'd5, 16'h1234);
    rom[3]  = mk_i(2'b01, 3'd0, 4'd4, 16'h00a0);
    rom[4]  = mk_i(2'b01, 3'd1, 4'd4, 16'h00b0);
    rom[5]  = mk_b(2'b10, 3'd1, 4'd1, 4'd2, 16'd7);
    rom[6]  = mk_r(2'b11, 3'd0, 4'd0, 4'd0, 4'd0);
    rom[7]  = mk_b(2'b10, 3'd2, 4'd1, 4'd2, 16'd10);
    rom[8]  = mk_b(2'b10, 3'd2, 4'd1, 4'd2, 16'd10);
    rom[9]  = mk_r(2'b11, 3'd0, 4'd0, 4'd0, 4'd0);
    rom[10] = mk_b(2'b10, 3'd0, 4'd15, 4'd15, 16'd12);
    rom[11] = mk_r(2'b11, 3'd0, 4'd0, 4'd0, 4'd0);
    rom[12] = mk_r(2'b11, 3'd2, 4'd1, 4'd1, 4'd1);
    rom[13] = mk_r(2'b00, 3'd6, 4'd1, 4'd1, 4'd1);
    rom[14] = mk_b(2'b10, 3'd1, 4'd1, 4'd2, 16'd0);
    rom[15] = mk_b(2'b10, 3'd0, 4'd0, 4'd0, 16'd0);

    t_reset();
    t_arith(16'd0, 3'd0, 4'd1, 4'd2, 4'd3);
    t_arith(16'd1, 3'd5, 4'd4, 4'd5, 4'd6);
    t_seti();
    t_load();
    t_store();
    t_branch(16'd5,  4'd14, 1'b0, 1'b1, 1'b1, 16'd7,  "R9 jne taken");
    t_branch(16'd7,  4'd15, 1'b0, 1'b1, 1'b0, 16'd8,  "R10 je not taken");
    t_branch(16'd8,  4'd15, 1'b1, 1'b1, 1'b1, 16'd10, "R10 je taken");
    t_branch(16'd10, 4'd13, 1'b1, 1'b0, 1'b1, 16'd12, "R8 jump zero high");
    t_undef(16'd12);
    t_undef(16'd13);
    t_branch(16'd14, 4'd14, 1'b1, 1'b1, 1'b0, 16'd15, "R9 jne not taken");
    t_branch(16'd15, 4'd13, 1'b0, 1'b0, 1'b1, 16'd0,  "R8 jump zero low");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule